// File: doc/BRIEF.md
# Block Cipher Engine Register Front-End

This block is the software-visible side of a block-cipher accelerator. A 32-bit bus with byte address, write strobe, read strobe and write data reaches a small set of registers: a configuration word that is locked while the engine runs, a control word that launches processing or marks a new message, interrupt enable and flag registers, a pointer-addressed four-word data buffer shared by input and output, write-only initialization vector words and key words. The cipher datapath sits outside. The front-end hands it the buffer, key, vector and configuration, pulses a start strobe, and takes the result back on a done strobe.

Software loads the buffer through one data port. A 2-bit pointer selects the word, and the pointer steps forward after every access. In manual mode the control word's go bit launches the engine. In automatic mode the launch follows the fourth data write counted since the pointer was last written or the last launch. While the engine works, the buffer is hidden. The result replaces the loaded words and raises a completion flag that can drive an interrupt.

Sequencing is a three-state machine. `ST_IDLE` (buffer visible) moves to `ST_LAUNCH` on a go request while enabled. `ST_LAUNCH` (start strobe high for one cycle) always moves to `ST_WAIT`. `ST_WAIT` returns to `ST_IDLE` on the done strobe (the capture transition), or on loss of enable (the abort transition).

Top module: `cipher_regfile`

## Requirements
- R1: After reset, every readable register (config 0x00, interrupt enable 0x08/0x0C, flag 0x10, pointer 0x14) reads zero, and `irq` and `eng_start` are low.
- R2: Config (0x00) keeps bits 19:16 and 14:1 and reads bits 0, 15 and 31:20 as zero. While bit 1 (enable) is set, a write with bit 1 set is ignored. A write with bit 1 clear only clears enable and leaves the other fields unchanged.
- R3: A permitted config write with bit 0 set returns every register, key word and vector word to zero on the following cycle.
- R4: The data port (0x18) reaches the word selected by the pointer (0x14, bits 1:0). Each data port access while idle advances the pointer by one, modulo 4.
- R5: While the engine is busy, data port reads return zero, and data port writes change neither the buffer nor the pointer.
- R6: With enable set and config bit 11 clear, writing bit 0 of control (0x04) pulses `eng_start` for exactly one cycle, with word n of the buffer on `eng_block[32n+31:32n]`.
- R7: With config bit 11 set, a launch occurs on the fourth data write counted since the last pointer write or launch. A pointer write restarts the count. The control go bit has no effect in this mode.
- R8: On `eng_done` the four buffer words are replaced by `eng_result` and read back through the data port.
- R9: Flag bit 0 (0x10) sets on `eng_done`. It clears on a write of 1 to it, on a manual launch, and on an idle data read when config bit 12 is clear, or on an idle data write when bit 12 is set.
- R10: Writing 1 to bit 0 of 0x08 sets the interrupt enable and writing 1 to bit 0 of 0x0C clears it. Both addresses read it back, and `irq` is the flag ANDed with the enable.
- R11: Vector words at 0x20 + 4n (n = 0..3) read as zero and appear on `eng_iv[32n+31:32n]`.
- R12: Key words at 0x40 + 4n (n = 0..7) appear on `eng_key[32n+31:32n]`. With config bit 14 set, a key write XORs the data into the stored word instead of replacing it.
- R13: Writing bit 1 of control raises `eng_newmsg`, which stays high through the next `eng_start` cycle and then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle launch strobe to the engine |
| eng_newmsg | output | 1 | New-message marker for the engine |
| eng_cfg | output | 32 | Current configuration word |
| eng_block | output | 128 | Buffer contents to the engine |
| eng_key | output | 256 | Key words |
| eng_iv | output | 128 | Initialization vector words |
| eng_done | input | 1 | Engine completion strobe |
| eng_result | input | 128 | Engine result block |

## Verification
Assertions check, on every cycle, the behaviours that are local in time. The start strobe is one cycle wide and only comes while enabled. The pointer wraps from 3 to 0. The buffer holds still and the data port reads zero while busy. The locked config does not move, and a capture always sets the flag. Only the bench scenarios can show the multi-step behaviours: the automatic-launch count and its restart on a pointer write, the full result round trip through the shared buffer, the separate flag-clearing paths, and the key XOR accumulation.

// File: rtl/cre_pkg.sv
package cre_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } cre_state_t;

    typedef struct packed {
        logic [11:0] rsv_hi;
        logic [3:0]  cm_type;
        logic        rsv_mid;
        logic        key_xor;
        logic        key_gen;
        logic        last_out;
        logic        auto_go;
        logic        decrypt;
        logic [1:0]  key_len;
        logic [2:0]  fb_size;
        logic [2:0]  op_mode;
        logic        enable;
        logic        sw_reset;
    } cre_cfg_t;

    localparam logic [31:0] CFG_KEEP = 32'h000F_7FFE;

    localparam int OFS_CFG  = 'h00;
    localparam int OFS_CTL  = 'h04;
    localparam int OFS_IEN1 = 'h08;
    localparam int OFS_IEN0 = 'h0C;
    localparam int OFS_FLAG = 'h10;
    localparam int OFS_PTR  = 'h14;
    localparam int OFS_DATA = 'h18;
    localparam int OFS_IV   = 'h20;
    localparam int OFS_KEY  = 'h40;

endpackage

// File: rtl/cre_seq.sv
module cre_seq
    import cre_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_i,
    input  logic en_i,
    input  logic go_i,
    input  logic done_i,
    output logic busy_o,
    output logic start_o,
    output logic capture_o
);

    cre_state_t state_q;
    cre_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (srst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_i && en_i) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (done_i || !en_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o    = 1'b0;
        start_o   = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_LAUNCH: begin
                busy_o  = 1'b1;
                start_o = 1'b1;
            end
            ST_WAIT: begin
                busy_o    = 1'b1;
                capture_o = done_i;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R6

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !$past(srst_i)) |-> $past(en_i)); // R6

endmodule

// File: rtl/cre_databuf.sv
module cre_databuf #(
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int PW   = $clog2(WORDS),
    localparam int CW   = $clog2(WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                srst_i,
    input  logic                busy_i,
    input  logic                ptr_wr_i,
    input  logic [PW-1:0]       ptr_wdata_i,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic                launch_i,
    input  logic                capture_i,
    input  logic [WORDS*DW-1:0] result_i,
    output logic [PW-1:0]       ptr_o,
    output logic [DW-1:0]       word_o,
    output logic [WORDS*DW-1:0] block_o,
    output logic                fill_last_o
);

    logic [PW-1:0] ptr_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] mem_q [WORDS];
    logic          acc_ok;
    logic          wr_ok;

    assign acc_ok = (wr_i || rd_i) && !busy_i;
    assign wr_ok  = wr_i && !busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (srst_i) begin
            ptr_q <= '0;
        end else if (ptr_wr_i) begin
            ptr_q <= ptr_wdata_i;
        end else if (acc_ok) begin
            ptr_q <= (ptr_q == PW'(WORDS - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (srst_i || ptr_wr_i || launch_i) begin
            cnt_q <= '0;
        end else if (wr_ok && cnt_q != CW'(WORDS)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < WORDS; gi++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[gi] <= '0;
                end else if (srst_i) begin
                    mem_q[gi] <= '0;
                end else if (capture_i) begin
                    mem_q[gi] <= result_i[gi*DW +: DW];
                end else if (wr_ok && ptr_q == PW'(gi)) begin
                    mem_q[gi] <= wdata_i;
                end
            end
            assign block_o[gi*DW +: DW] = mem_q[gi];
        end
    endgenerate

    assign ptr_o       = ptr_q;
    assign word_o      = mem_q[ptr_q];
    assign fill_last_o = (cnt_q == CW'(WORDS - 1));

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && !ptr_wr_i && !srst_i && ptr_q == PW'(WORDS - 1)) |=> (ptr_q == '0)); // R4

    AST_BUSY_HOLDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !capture_i && !srst_i) |=> $stable(block_o)); // R5

endmodule

// File: rtl/cre_keyiv.sv
module cre_keyiv #(
    parameter int DW        = 32,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    localparam int KIW      = $clog2(KEY_WORDS),
    localparam int VIW      = $clog2(IV_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    srst_i,
    input  logic                    key_wr_i,
    input  logic [KIW-1:0]          key_idx_i,
    input  logic                    xor_i,
    input  logic                    iv_wr_i,
    input  logic [VIW-1:0]          iv_idx_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [KEY_WORDS*DW-1:0] key_o,
    output logic [IV_WORDS*DW-1:0]  iv_o
);

    genvar gk;
    generate
        for (gk = 0; gk < KEY_WORDS; gk++) begin : g_key
            logic [DW-1:0] kw_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    kw_q <= '0;
                end else if (srst_i) begin
                    kw_q <= '0;
                end else if (key_wr_i && key_idx_i == KIW'(gk)) begin
                    kw_q <= xor_i ? (kw_q ^ wdata_i) : wdata_i;
                end
            end
            assign key_o[gk*DW +: DW] = kw_q;
        end

        for (gk = 0; gk < IV_WORDS; gk++) begin : g_iv
            logic [DW-1:0] vw_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vw_q <= '0;
                end else if (srst_i) begin
                    vw_q <= '0;
                end else if (iv_wr_i && iv_idx_i == VIW'(gk)) begin
                    vw_q <= wdata_i;
                end
            end
            assign iv_o[gk*DW +: DW] = vw_q;
        end
    endgenerate

endmodule

// File: rtl/cipher_regfile.sv
module cipher_regfile
    import cre_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int WORDS     = 4,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    localparam int PW       = $clog2(WORDS),
    localparam int KIW      = $clog2(KEY_WORDS),
    localparam int VIW      = $clog2(IV_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    output logic                    irq,
    output logic                    eng_start,
    output logic                    eng_newmsg,
    output logic [DW-1:0]           eng_cfg,
    output logic [WORDS*DW-1:0]     eng_block,
    output logic [KEY_WORDS*DW-1:0] eng_key,
    output logic [IV_WORDS*DW-1:0]  eng_iv,
    input  logic                    eng_done,
    input  logic [WORDS*DW-1:0]     eng_result
);

    // address decode
    logic hit_cfg, hit_ctl, hit_ien1, hit_ien0, hit_flag, hit_ptr, hit_data, hit_iv, hit_key;

    assign hit_cfg  = (bus_addr == AW'(OFS_CFG));
    assign hit_ctl  = (bus_addr == AW'(OFS_CTL));
    assign hit_ien1 = (bus_addr == AW'(OFS_IEN1));
    assign hit_ien0 = (bus_addr == AW'(OFS_IEN0));
    assign hit_flag = (bus_addr == AW'(OFS_FLAG));
    assign hit_ptr  = (bus_addr == AW'(OFS_PTR));
    assign hit_data = (bus_addr == AW'(OFS_DATA));
    assign hit_iv   = (bus_addr >= AW'(OFS_IV))  && (bus_addr < AW'(OFS_IV + 4 * IV_WORDS));
    assign hit_key  = (bus_addr >= AW'(OFS_KEY)) && (bus_addr < AW'(OFS_KEY + 4 * KEY_WORDS));

    // configuration with enable lock
    cre_cfg_t cfg_q;
    logic     cfg_wr, cfg_open, cfg_drop_en, srst;

    assign cfg_wr      = bus_wr && hit_cfg;
    assign cfg_drop_en = cfg_wr && cfg_q.enable && !bus_wdata[1];
    assign cfg_open    = cfg_wr && !cfg_q.enable;
    assign srst        = (cfg_open || cfg_drop_en) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (srst) begin
            cfg_q <= '0;
        end else if (cfg_drop_en) begin
            cfg_q.enable <= 1'b0;
        end else if (cfg_open) begin
            cfg_q <= cre_cfg_t'(bus_wdata & CFG_KEEP);
        end
    end

    // sequencing
    logic busy, capture, go_manual, go_auto, go, fill_last;
    logic data_wr, data_rd;

    assign data_wr   = bus_wr && hit_data;
    assign data_rd   = bus_rd && hit_data;
    assign go_manual = bus_wr && hit_ctl && bus_wdata[0] && cfg_q.enable && !cfg_q.auto_go && !busy;
    assign go_auto   = data_wr && !busy && cfg_q.enable && cfg_q.auto_go && fill_last;
    assign go        = go_manual || go_auto;

    cre_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_i    (srst),
        .en_i      (cfg_q.enable),
        .go_i      (go),
        .done_i    (eng_done),
        .busy_o    (busy),
        .start_o   (eng_start),
        .capture_o (capture)
    );

    // shared buffer
    logic [PW-1:0] ptr;
    logic [DW-1:0] buf_word;

    cre_databuf #(
        .DW    (DW),
        .WORDS (WORDS)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst_i      (srst),
        .busy_i      (busy),
        .ptr_wr_i    (bus_wr && hit_ptr),
        .ptr_wdata_i (bus_wdata[PW-1:0]),
        .wr_i        (data_wr),
        .rd_i        (data_rd),
        .wdata_i     (bus_wdata),
        .launch_i    (go),
        .capture_i   (capture),
        .result_i    (eng_result),
        .ptr_o       (ptr),
        .word_o      (buf_word),
        .block_o     (eng_block),
        .fill_last_o (fill_last)
    );

    // key and vector words
    cre_keyiv #(
        .DW        (DW),
        .KEY_WORDS (KEY_WORDS),
        .IV_WORDS  (IV_WORDS)
    ) u_keyiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_i    (srst),
        .key_wr_i  (bus_wr && hit_key),
        .key_idx_i (bus_addr[KIW+1:2]),
        .xor_i     (cfg_q.key_xor),
        .iv_wr_i   (bus_wr && hit_iv),
        .iv_idx_i  (bus_addr[VIW+1:2]),
        .wdata_i   (bus_wdata),
        .key_o     (eng_key),
        .iv_o      (eng_iv)
    );

    // new-message marker
    logic newmsg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            newmsg_q <= 1'b0;
        end else if (srst) begin
            newmsg_q <= 1'b0;
        end else if (bus_wr && hit_ctl && bus_wdata[1]) begin
            newmsg_q <= 1'b1;
        end else if (eng_start) begin
            newmsg_q <= 1'b0;
        end
    end

    // interrupt enable and completion flag
    logic ien_q, flag_q, flag_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (srst) begin
            ien_q <= 1'b0;
        end else if (bus_wr && hit_ien1 && bus_wdata[0]) begin
            ien_q <= 1'b1;
        end else if (bus_wr && hit_ien0 && bus_wdata[0]) begin
            ien_q <= 1'b0;
        end
    end

    assign flag_clr = (bus_wr && hit_flag && bus_wdata[0])
                   || go_manual
                   || (data_rd && !busy && !cfg_q.last_out)
                   || (data_wr && !busy && cfg_q.last_out);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (srst) begin
            flag_q <= 1'b0;
        end else if (capture) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign irq        = flag_q && ien_q;
    assign eng_newmsg = newmsg_q;
    assign eng_cfg    = cfg_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (hit_cfg) begin
            bus_rdata = cfg_q;
        end else if (hit_ien1 || hit_ien0) begin
            bus_rdata = DW'(ien_q);
        end else if (hit_flag) begin
            bus_rdata = DW'(flag_q);
        end else if (hit_ptr) begin
            bus_rdata = DW'(ptr);
        end else if (hit_data && !busy) begin
            bus_rdata = buf_word;
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.enable && !cfg_drop_en) |=> $stable(cfg_q)); // R2

    AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_rd && hit_data) |-> (bus_rdata == '0)); // R5

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !srst) |=> flag_q); // R9

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (cfg_q == '0 && !flag_q && !ien_q && !newmsg_q)); // R3

endmodule

// File: tb/cipher_regfile_tb.sv
module cipher_regfile_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [7:0]   bus_addr;
    logic         bus_wr, bus_rd;
    logic [31:0]  bus_wdata, bus_rdata;
    logic         irq, eng_start, eng_newmsg, eng_done;
    logic [31:0]  eng_cfg;
    logic [127:0] eng_block, eng_iv, eng_result;
    logic [255:0] eng_key;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [127:0] exp_blk_q [$];
    logic         exp_nm_q  [$];
    logic [31:0]  w [4];

    always #10 clk = ~clk;

    cipher_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_start(eng_start),
        .eng_newmsg(eng_newmsg), .eng_cfg(eng_cfg), .eng_block(eng_block), .eng_key(eng_key),
        .eng_iv(eng_iv), .eng_done(eng_done), .eng_result(eng_result)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v === e, req, 128'(v), 128'(e));
    endtask

    task automatic expect_launch(input logic [127:0] blk, input logic nm);
        exp_blk_q.push_back(blk);
        exp_nm_q.push_back(nm);
    endtask

    task automatic wait_flag();
        logic [31:0] v;
        bit seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            rd(8'h10, v);
            seen = v[0];
        end
        check(seen, "R9 flag never set", 128'(seen), 128'd1);
    endtask

    // engine model
    initial begin
        logic [127:0] blk;
        eng_done = 1'b0; eng_result = '0;
        forever begin
            @(negedge clk);
            if (rst_n && eng_start) begin
                blk = eng_block;
                repeat (10) @(negedge clk);
                eng_result = ~blk; eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && eng_start) begin
            if (exp_blk_q.size() == 0) begin
                check(1'b0, "R7 unexpected launch", eng_block, 128'd0);
            end else begin
                logic [127:0] eb;
                logic         en;
                eb = exp_blk_q.pop_front();
                en = exp_nm_q.pop_front();
                check(eng_block === eb, "R6 launch block", eng_block, eb);
                check(eng_newmsg === en, "R13 newmsg at launch", 128'(eng_newmsg), 128'(en));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_chk(8'h00, 32'h0, "R1 cfg");
        rd_chk(8'h08, 32'h0, "R1 ien");
        rd_chk(8'h10, 32'h0, "R1 flag");
        rd_chk(8'h14, 32'h0, "R1 ptr");
        check(irq === 1'b0 && eng_start === 1'b0, "R1 irq/start", 128'({irq, eng_start}), 128'd0);

        // R2 field mask, R3 soft reset
        wr(8'h00, 32'hFFFF_FFFC);
        rd_chk(8'h00, 32'h000F_7FFC, "R2 cfg mask");
        wr(8'h14, 32'h2);
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h1);
        rd_chk(8'h00, 32'h0, "R3 cfg cleared");
        rd_chk(8'h14, 32'h0, "R3 ptr cleared");
        rd_chk(8'h08, 32'h0, "R3 ien cleared");

        // R2 lock
        wr(8'h00, 32'h6);
        rd_chk(8'h00, 32'h6, "R2 enable write");
        wr(8'h00, 32'h000F_0FFE);
        rd_chk(8'h00, 32'h6, "R2 locked write ignored");
        wr(8'h00, 32'h10);
        rd_chk(8'h00, 32'h4, "R2 clear-enable keeps fields");
        wr(8'h00, 32'h6);

        // R4 pointer stepping with wrap
        w[0] = 32'h1111_0000; w[1] = 32'h2222_0001; w[2] = 32'h3333_0002; w[3] = 32'h4444_0003;
        wr(8'h14, 32'h3);
        wr(8'h18, w[3]);
        rd_chk(8'h14, 32'h0, "R4 ptr wraps 3->0");
        wr(8'h18, w[0]); wr(8'h18, w[1]); wr(8'h18, w[2]);
        rd_chk(8'h14, 32'h3, "R4 ptr after writes");
        wr(8'h14, 32'h0);
        for (int i = 0; i < 4; i++) rd_chk(8'h18, w[i], "R4 word readback");

        // R6 manual launch with R13 newmsg, R5 busy hiding
        wr(8'h08, 32'h1);
        wr(8'h04, 32'h2);
        check(eng_newmsg === 1'b1, "R13 newmsg raised", 128'(eng_newmsg), 128'd1);
        expect_launch({w[3], w[2], w[1], w[0]}, 1'b1);
        wr(8'h04, 32'h1);
        rd_chk(8'h18, 32'h0, "R5 busy read zero");
        wr(8'h18, 32'hDEAD_BEEF);
        wait_flag();
        check(eng_newmsg === 1'b0, "R13 newmsg dropped", 128'(eng_newmsg), 128'd0);
        check(irq === 1'b1, "R10 irq with flag and enable", 128'(irq), 128'd1);
        rd_chk(8'h14, 32'h0, "R5 ptr unchanged by busy access");
        for (int i = 0; i < 4; i++) w[i] = ~w[i];
        rd_chk(8'h18, w[0], "R8 result word0");
        rd_chk(8'h10, 32'h0, "R9 data read clears flag");
        for (int i = 1; i < 4; i++) rd_chk(8'h18, w[i], "R8 result word");
        check(irq === 1'b0, "R10 irq low after clear", 128'(irq), 128'd0);

        // second launch: R10 enable paths, R9 W1C
        expect_launch({w[3], w[2], w[1], w[0]}, 1'b0);
        wr(8'h04, 32'h1);
        wait_flag();
        for (int i = 0; i < 4; i++) w[i] = ~w[i];
        wr(8'h0C, 32'h1);
        rd_chk(8'h08, 32'h0, "R10 ien cleared");
        check(irq === 1'b0, "R10 irq masked", 128'(irq), 128'd0);
        wr(8'h08, 32'h1);
        check(irq === 1'b1, "R10 irq unmasked", 128'(irq), 128'd1);

        // third launch: manual start clears flag
        expect_launch({w[3], w[2], w[1], w[0]}, 1'b0);
        wr(8'h04, 32'h1);
        rd_chk(8'h10, 32'h0, "R9 manual start clears flag");
        wait_flag();
        wr(8'h10, 32'h1);
        rd_chk(8'h10, 32'h0, "R9 write-one clears flag");
        check(irq === 1'b0, "R10 irq after W1C", 128'(irq), 128'd0);

        // R7 automatic launch
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h802);
        rd_chk(8'h00, 32'h802, "R7 auto cfg");
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hA0); wr(8'h18, 32'hA1); wr(8'h18, 32'hA2);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hB0); wr(8'h18, 32'hB1); wr(8'h18, 32'hB2);
        repeat (4) @(negedge clk);
        check(exp_blk_q.size() == 0, "R7 no early launch", 128'(exp_blk_q.size()), 128'd0);
        expect_launch({32'hB3, 32'hB2, 32'hB1, 32'hB0}, 1'b0);
        wr(8'h18, 32'hB3);
        wait_flag();
        wr(8'h04, 32'h1);
        repeat (15) @(negedge clk);
        rd_chk(8'h10, 32'h1, "R7 go bit ignored in auto mode");

        // R9 last-output variant
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h1802);
        rd(8'h18, v);
        rd_chk(8'h10, 32'h1, "R9 read keeps flag when last-out set");
        wr(8'h18, 32'h0);
        rd_chk(8'h10, 32'h0, "R9 write clears flag when last-out set");

        // R11 vector words
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h0);
        for (int i = 0; i < 4; i++) wr(8'(8'h20 + 4 * i), 32'hC0DE_0000 + 32'(i));
        for (int i = 0; i < 4; i++) rd_chk(8'(8'h20 + 4 * i), 32'h0, "R11 iv reads zero");
        check(eng_iv === {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000},
              "R11 iv on port", eng_iv, {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000});

        // R12 key XOR
        wr(8'h44, 32'h1234);
        check(eng_key[63:32] === 32'h1234, "R12 key replace", 128'(eng_key[63:32]), 128'h1234);
        wr(8'h00, 32'h4000);
        wr(8'h44, 32'h00FF);
        check(eng_key[63:32] === 32'h12CB, "R12 key xor", 128'(eng_key[63:32]), 128'h12CB);
        wr(8'h00, 32'h0);
        wr(8'h44, 32'h5555);
        check(eng_key[63:32] === 32'h5555, "R12 key replace again", 128'(eng_key[63:32]), 128'h5555);
        rd_chk(8'h44, 32'h0, "R12 key reads zero");

        // R3 soft reset clears everything
        wr(8'h14, 32'h2);
        wr(8'h04, 32'h2);
        wr(8'h00, 32'h1);
        rd_chk(8'h14, 32'h0, "R3 ptr after soft reset");
        check(eng_key === '0 && eng_iv === '0 && eng_newmsg === 1'b0, "R3 key/iv/newmsg cleared",
              128'({eng_newmsg, |eng_key, |eng_iv}), 128'd0);

        repeat (20) @(negedge clk);
        check(exp_blk_q.size() == 0, "R6 all launches seen", 128'(exp_blk_q.size()), 128'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule